// File: doc/BRIEF.md
# Cartridge ROM Bank Mapper

The mapper sits between a CPU's 16-bit read bus and a flat cartridge ROM. It turns each CPU read address into an absolute ROM byte address. Addresses in the lower 16 KiB (0x0000-0x3FFF) pass straight through. Addresses in the upper 16 KiB of the ROM space (0x4000-0x7FFF) are relocated into a selectable 16 KiB bank.

The selected bank is built from three writable settings:
- a 5-bit low bank number,
- a 2-bit high bank field,
- a one-bit banking mode.

The CPU sets these by writing into the ROM address range through a separate register-write port. In mode 0 the high field supplies bank bits 6:5 of the switchable window. In mode 1 the high field is left out and only the low number selects the bank.

Each accepted read produces the ROM address and a valid strobe one clock later, which suits a synchronous ROM. The result is masked to the ROM size, given as a number of 16 KiB banks.

Top module: `rom_bank_mapper`

## Requirements
- R1: After reset the low bank number is 1, the high field is 0 and the mode is 0. A read of 0x4000 then yields ROM address 0x04000.
- R2: A read of an address in 0x0000-0x3FFF yields the same value as the ROM address, with all upper bits zero.
- R3: A read of an address A in 0x4000-0x7FFF yields ROM address bank*0x4000 + (A - 0x4000), where bank is the selected bank number.
- R4: A write whose address bits 15:13 are 3'b001 (0x2000-0x3FFF) loads the low bank number from data bits 4:0. Data bits 7:5 are ignored. A loaded value of 0 is stored as 1.
- R5: A write whose address bits 15:13 are 3'b010 (0x4000-0x5FFF) loads the high field from data bits 1:0.
- R6: A write whose address bits 15:13 are 3'b011 (0x6000-0x7FFF) loads the mode from data bit 0.
- R7: The selected bank is {high, low} when the mode is 0, and {2'b00, low} when the mode is 1.
- R8: The ROM address is truncated to log2(NUM_BANKS)+14 bits, so bank numbers wrap modulo NUM_BANKS.
- R9: When rd_en is low, or rd_addr bit 15 is set, rom_valid is low on the next cycle.
- R10: Writes to 0x0000-0x1FFF or to 0x8000-0xFFFF change no setting.
- R11: A read and a write in the same cycle use the settings in force before that write.
- R12: A read issued with rd_en high and rd_addr below 0x8000 drives rom_valid high with its address exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 16 | CPU address of the setting write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 16 | CPU read address |
| rom_addr | output | log2(NUM_BANKS)+14 | Absolute ROM byte address |
| rom_valid | output | 1 | rom_addr holds a read issued the cycle before |

## Verification
The assertions take for granted three things about the block's environment:
- NUM_BANKS is a power of two of at least 2.
- rd_addr and wr_addr carry known values whenever their strobes are high.
- Reset is applied before the first read.

The stimulus drives every input on the falling clock edge with defined values. It holds rd_en and wr_en low while the bench is idle and during reset. It samples results one full clock after each request. Reads above 0x7FFF are issued on purpose, and only to confirm that they are refused.

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper #(
  parameter int NUM_BANKS = 64,
  parameter int LOW_W     = 5,
  parameter int HIGH_W    = 2,
  parameter int ROM_AW    = $clog2(NUM_BANKS) + 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [15:0]       rd_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_valid
);
  localparam int SEL_W  = LOW_W + HIGH_W;
  localparam int WIDE_W = SEL_W + 14;

  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;
  logic              mode_q;

  wire wr_low  = wr_en && (wr_addr[15:13] == 3'b001);
  wire wr_high = wr_en && (wr_addr[15:13] == 3'b010);
  wire wr_mode = wr_en && (wr_addr[15:13] == 3'b011);

  wire [LOW_W-1:0] low_in = wr_data[LOW_W-1:0];

  logic unused_bits;
  assign unused_bits = &{wr_addr[12:0], wr_data[7:LOW_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= LOW_W'(1);
      high_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (wr_low)  low_q  <= (low_in == '0) ? LOW_W'(1) : low_in;
      if (wr_high) high_q <= wr_data[HIGH_W-1:0];
      if (wr_mode) mode_q <= wr_data[0];
    end
  end

  wire [SEL_W-1:0]  bank_sel = mode_q ? {{HIGH_W{1'b0}}, low_q} : {high_q, low_q};
  wire [WIDE_W-1:0] sw_wide  = {bank_sel, rd_addr[13:0]};
  logic [ROM_AW-1:0] sw_addr;
  wire  [ROM_AW-1:0] fx_addr = {{(ROM_AW-14){1'b0}}, rd_addr[13:0]};

  generate
    if (ROM_AW <= WIDE_W) begin : g_trunc
      assign sw_addr = sw_wide[ROM_AW-1:0];
    end else begin : g_ext
      assign sw_addr = {{(ROM_AW-WIDE_W){1'b0}}, sw_wide};
    end
  endgenerate

  wire rd_ok = rd_en && !rd_addr[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_addr  <= '0;
      rom_valid <= 1'b0;
    end else begin
      rom_valid <= rd_ok;
      if (rd_ok) rom_addr <= rd_addr[14] ? sw_addr : fx_addr;
    end
  end
endmodule

// File: rtl/rom_bank_mapper_chk.sv
module rom_bank_mapper_chk #(
  parameter int ROM_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [15:0]       rd_addr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_valid
);
  // R12
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_addr[15]) |=> rom_valid);

  // R9
  refused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !rd_addr[15]) |=> !rom_valid);

  // R2
  fixed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[15:14] == 2'b00) |=>
      (rom_addr[13:0] == $past(rd_addr[13:0]) && rom_addr[ROM_AW-1:14] == '0));

  // R3
  switch_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[15:14] == 2'b01) |=> rom_addr[13:0] == $past(rd_addr[13:0]));
endmodule

bind rom_bank_mapper rom_bank_mapper_chk #(.ROM_AW(ROM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .rom_addr(rom_addr), .rom_valid(rom_valid)
);

// File: tb/tb_rom_bank_mapper.sv
module tb_rom_bank_mapper;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_en = 1'b0;
  logic [15:0]   rd_addr = '0;
  logic [AW-1:0] rom_addr;
  logic          rom_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rom_bank_mapper #(.NUM_BANKS(64)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rom_addr(rom_addr), .rom_valid(rom_valid)
  );

  task automatic chk(string req, logic [AW-1:0] got_a, logic got_v,
                     logic [AW-1:0] exp_a, logic exp_v);
    checks++;
    if (got_v !== exp_v || (exp_v && got_a !== exp_a)) begin
      fails++;
      $display("FAIL %s: got addr=%05h valid=%0b, expected addr=%05h valid=%0b",
               req, got_a, got_v, exp_a, exp_v);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic en, logic [15:0] a, logic [AW-1:0] exp_a, logic exp_v);
    @(negedge clk);
    rd_en = en; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rom_addr, rom_valid, exp_a, exp_v);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    rd("R1 reset bank", 1'b1, 16'h4000, 20'h04000, 1'b1);
    rd("R1 reset bank top", 1'b1, 16'h7FFF, 20'h07FFF, 1'b1);
  endtask

  task automatic t_fixed;
    rd("R2 fixed 0000", 1'b1, 16'h0000, 20'h00000, 1'b1);
    rd("R2 fixed 1234", 1'b1, 16'h1234, 20'h01234, 1'b1);
    rd("R2 fixed 3FFF", 1'b1, 16'h3FFF, 20'h03FFF, 1'b1);
  endtask

  task automatic t_low;
    wr(16'h2000, 8'h05);
    rd("R3 R4 bank 5", 1'b1, 16'h4010, 20'h14010, 1'b1);
    wr(16'h3FFF, 8'h00);
    rd("R4 zero as one", 1'b1, 16'h4000, 20'h04000, 1'b1);
    wr(16'h2ABC, 8'hE3);
    rd("R4 upper data ignored", 1'b1, 16'h5000, 20'h0D000, 1'b1);
  endtask

  task automatic t_high_mode;
    wr(16'h4000, 8'h01);
    rd("R5 R7 mode0 merge", 1'b1, 16'h4000, 20'h8C000, 1'b1);
    wr(16'h6000, 8'h01);
    rd("R6 R7 mode1 excludes high", 1'b1, 16'h4000, 20'h0C000, 1'b1);
    wr(16'h7FFF, 8'hFE);
    rd("R6 bit0 only", 1'b1, 16'h4000, 20'h8C000, 1'b1);
  endtask

  task automatic t_mask;
    wr(16'h5FFF, 8'h02);
    rd("R8 bank 67 wraps to 3", 1'b1, 16'h4000, 20'h0C000, 1'b1);
    wr(16'h4000, 8'h03);
    wr(16'h2000, 8'h1F);
    rd("R8 bank 127 wraps to 63", 1'b1, 16'h7FFF, 20'hFFFFF, 1'b1);
  endtask

  task automatic t_refused;
    rd("R9 read above 7FFF", 1'b1, 16'h8000, 20'h00000, 1'b0);
    rd("R9 read FFFF", 1'b1, 16'hFFFF, 20'h00000, 1'b0);
    rd("R9 rd_en low", 1'b0, 16'h4000, 20'h00000, 1'b0);
  endtask

  task automatic t_ignored;
    wr(16'h4000, 8'h00);
    wr(16'h2000, 8'h02);
    wr(16'h1000, 8'h07);
    wr(16'h0000, 8'h01);
    wr(16'h9000, 8'h07);
    wr(16'hC000, 8'h03);
    wr(16'hE000, 8'h01);
    rd("R10 ignored writes", 1'b1, 16'h4000, 20'h08000, 1'b1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h2000; wr_data = 8'h04;
    rd_en = 1'b1; rd_addr = 16'h4000;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 read sees old bank", rom_addr, rom_valid, 20'h08000, 1'b1);
    rd("R11 next read sees new bank", 1'b1, 16'h4000, 20'h10000, 1'b1);
  endtask

  task automatic t_latency;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 16'h0ABC;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R12 one-cycle result", rom_addr, rom_valid, 20'h00ABC, 1'b1);
    @(negedge clk);
    chk("R12 strobe drops", rom_addr, rom_valid, 20'h00000, 1'b0);
  endtask

  task automatic t_rereset;
    wr(16'h6000, 8'h01);
    do_reset();
    rd("R1 reset restores defaults", 1'b1, 16'h4000, 20'h04000, 1'b1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_fixed();
    t_low();
    t_high_mode();
    t_mask();
    t_refused();
    t_ignored();
    t_same_cycle();
    t_latency();
    t_rereset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule